// File: doc/BRIEF.md
# Auto Exposure Hysteresis Controller

This block closes the exposure loop of an image pipeline. Once per frame it takes a 12-bit measured luminance, smooths it over frames, and compares the upper eight bits of the smoothed value with a programmable reference level. When the picture is too dark or too bright it moves an electronic shutter index first. Only when the shutter cannot move further does it step an AGC gain.

Two tolerance bands around the reference give hysteresis. While regulating, the controller stops and reports itself settled once the error falls inside the narrow stop band. From the settled state it wakes up only when the error leaves the wider restart band. A backlight input swaps in a second set of reference and band values. A two-bit mode can pin the shutter to a fixed value, pin the gain to a preset, or do both.

Top module: `ae_hyst_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `shutter_idx` is 75, `agc_gain` is 0 and `settled` is 0, in mode 00.
- R2: On each frame strobe the smoothed value becomes the new luminance when `smooth_sel[1]`=1. It becomes (3·old+new)>>2 when `smooth_sel`=01 and (7·old+new)>>3 when `smooth_sel`=00, starting from 0 after reset. The measurement is the smoothed value shifted right by 4.
- R3: When `backlight_en`=1 the reference, stop band and restart band are taken from the `*_blc` inputs. Otherwise they are taken from the `*_norm` inputs.
- R4: The error is measurement minus reference. A frame acts when |error| exceeds the stop band while unsettled, or exceeds the restart band while settled. After each strobe `settled` equals the inverse of "acts". A frame that does not act changes neither the shutter nor the gain.
- R5: The shutter step is 1 when `step_speed[1]`=1, 8+min(|e|>>4,2) when `step_speed`=01, and 10+min(|e|>>4,9) when `step_speed`=00. A negative error raises the index and a positive error lowers it.
- R6: In automatic shutter modes the index stays at or below 149. When too dark it is raised to at least the floor, which is 16·`limit_sel`. When too bright it never goes below the floor, and when it is already at or below the floor it is set to the floor.
- R7: The gain steps by exactly 1, up when dark and down when bright. It changes only when the shutter is fixed, already at 149 (dark), or at or below the floor (bright). It saturates at 0 and 255.
- R8: `exp_mode[0]`=1 (modes 01 and 11) makes `shutter_idx` equal min(`fixed_shutter`,149), and the internal index is not moved.
- R9: `exp_mode[1]`=1 (modes 10 and 11) makes `agc_gain` equal `preset_gain`. The internal gain is frozen and resumes from its held value when AGC is turned back on.
- R10: Outputs change only at a clock edge where `frame_stb` is high. Luminance changes between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per frame, qualifies `luma_in` |
| luma_in | input | 12 | Measured frame luminance |
| backlight_en | input | 1 | Select backlight register set |
| ref_norm | input | 8 | Reference level, normal set |
| stop_norm | input | 8 | Stop (narrow) band, normal set |
| restart_norm | input | 8 | Restart (wide) band, normal set |
| ref_blc | input | 8 | Reference level, backlight set |
| stop_blc | input | 8 | Stop band, backlight set |
| restart_blc | input | 8 | Restart band, backlight set |
| exp_mode | input | 2 | bit0 fixed shutter, bit1 AGC off |
| step_speed | input | 2 | Shutter step size selection |
| smooth_sel | input | 2 | Luminance smoothing selection |
| limit_sel | input | 2 | Shutter floor selection (fastest speed) |
| fixed_shutter | input | 9 | Fixed shutter index |
| preset_gain | input | 8 | Gain used while AGC is off |
| shutter_idx | output | 9 | Applied shutter index |
| agc_gain | output | 8 | Applied AGC gain |
| settled | output | 1 | High while in the hold state |

## Verification
Gain saturation is the hardest state to reach from the ports. The gain moves by one per frame, and only after the shutter has run into a limit, so reaching 255 takes hundreds of acting frames with the loop held open. The stimulus gets there by selecting fixed shutter with AGC on and feeding black frames for 270 strobes, then checks that the gain holds at 255. Hysteresis is exercised with random luminance around the reference, so that frames land between the two bands in both the settled and the unsettled state.

// File: rtl/ae_pkg.sv
package ae_pkg;
    localparam int LUMA_W = 12;
    localparam int REG_W  = 8;
    localparam int SH_W   = 9;
    localparam int GAIN_W = 8;
    localparam int MEAS_SHIFT = LUMA_W - REG_W;

    typedef struct packed {
        logic [REG_W-1:0] ref_lvl;
        logic [REG_W-1:0] stop_band;
        logic [REG_W-1:0] restart_band;
    } band_t;

    typedef enum logic [1:0] {
        EXP_AUTO_AGC   = 2'b00,
        EXP_FIX_AGC    = 2'b01,
        EXP_AUTO_NOAGC = 2'b10,
        EXP_FIX_NOAGC  = 2'b11
    } exp_mode_e;

    // shutter step for the selected speed and error magnitude
    function automatic logic [4:0] step_of(input logic [1:0] speed,
                                           input logic [REG_W:0] mag);
        logic [4:0] coarse;
        coarse = 5'(mag >> 4);
        if (speed[1])
            return 5'd1;
        else if (speed[0])
            return 5'd8 + ((coarse > 5'd2) ? 5'd2 : coarse);
        else
            return 5'd10 + ((coarse > 5'd9) ? 5'd9 : coarse);
    endfunction
endpackage

// File: rtl/ae_band_sel.sv
module ae_band_sel
    import ae_pkg::*;
(
    input  logic  use_blc,
    input  band_t norm_set,
    input  band_t blc_set,
    output band_t active
);
    always_comb active = use_blc ? blc_set : norm_set;
endmodule

// File: rtl/ae_luma_filter.sv
module ae_luma_filter
    import ae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [LUMA_W-1:0] luma,
    input  logic [1:0]        smooth,
    output logic [LUMA_W-1:0] filt_next
);
    localparam int ACC_W = LUMA_W + 3;

    logic [LUMA_W-1:0] filt_q;
    logic [ACC_W-1:0]  acc3, acc7;

    always_comb begin
        acc3 = ACC_W'(filt_q) * ACC_W'(3) + ACC_W'(luma);
        acc7 = ACC_W'(filt_q) * ACC_W'(7) + ACC_W'(luma);
        if (smooth[1])
            filt_next = luma;
        else if (smooth[0])
            filt_next = LUMA_W'(acc3 >> 2);
        else
            filt_next = LUMA_W'(acc7 >> 3);
    end

    always_ff @(posedge clk) begin
        if (rst)
            filt_q <= '0;
        else if (stb)
            filt_q <= filt_next;
    end

    assert_filter_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        stb |=> (filt_q <= ((luma_hi_q > filt_hi_q) ? luma_hi_q : filt_hi_q)));

    logic [LUMA_W-1:0] luma_hi_q, filt_hi_q;
    always_ff @(posedge clk) begin
        luma_hi_q <= luma;
        filt_hi_q <= filt_q;
    end
endmodule

// File: rtl/ae_exposure_core.sv
module ae_exposure_core
    import ae_pkg::*;
#(
    parameter int SHUTTER_MAX  = 149,
    parameter int SHUTTER_INIT = 75,
    parameter int LIMIT_STEP   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [REG_W-1:0]  meas,
    input  band_t             band,
    input  logic [1:0]        mode,
    input  logic [1:0]        speed,
    input  logic [1:0]        limit_sel,
    output logic [SH_W-1:0]   sh_q,
    output logic [GAIN_W-1:0] gain_q,
    output logic              settled_q
);
    localparam logic [SH_W-1:0]   SH_TOP  = SH_W'(SHUTTER_MAX);
    localparam logic [GAIN_W-1:0] GAIN_TOP = '1;

    logic signed [REG_W+1:0] err;
    logic [REG_W:0]          mag;
    logic                    dark, act, fixed_sh, agc_on;
    logic [4:0]              step;
    logic [SH_W-1:0]         floor_idx, sh_n;
    logic [SH_W:0]           sum;
    logic [GAIN_W-1:0]       gain_n;

    always_comb begin
        err       = $signed({2'b00, meas}) - $signed({2'b00, band.ref_lvl});
        dark      = err[REG_W+1];
        mag       = dark ? (REG_W+1)'(-err) : (REG_W+1)'(err);
        act       = settled_q ? (mag > {1'b0, band.restart_band})
                              : (mag > {1'b0, band.stop_band});
        fixed_sh  = mode[0];
        agc_on    = !mode[1];
        step      = step_of(speed, mag);
        floor_idx = SH_W'(limit_sel) * SH_W'(LIMIT_STEP);
        sum       = {1'b0, sh_q} + (SH_W+1)'(step);

        sh_n   = sh_q;
        gain_n = gain_q;
        if (act) begin
            if (dark) begin
                if (!fixed_sh && sh_q < SH_TOP) begin
                    sh_n = (sum > {1'b0, SH_TOP}) ? SH_TOP : sum[SH_W-1:0];
                    if (sh_n < floor_idx) sh_n = floor_idx;
                end else if (agc_on && gain_q != GAIN_TOP) begin
                    gain_n = gain_q + 1'b1;
                end
            end else begin
                if (!fixed_sh && sh_q > floor_idx) begin
                    sh_n = ((sh_q - floor_idx) <= SH_W'(step)) ? floor_idx
                                                              : sh_q - SH_W'(step);
                end else begin
                    if (!fixed_sh) sh_n = floor_idx;
                    if (agc_on && gain_q != '0) gain_n = gain_q - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= SH_W'(SHUTTER_INIT);
            gain_q    <= '0;
            settled_q <= 1'b0;
        end else if (stb) begin
            sh_q      <= sh_n;
            gain_q    <= gain_n;
            settled_q <= !act;
        end
    end

    assert_shutter_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
        sh_q <= SH_TOP);

    assert_quiet_between_frames_R10: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(sh_q) && $stable(gain_q) && $stable(settled_q)));

    assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (rst)
        (settled_q && $past(settled_q)) |-> ($stable(sh_q) && $stable(gain_q)));

    assert_gain_unit_step_R7: assert property (@(posedge clk) disable iff (rst)
        (gain_q != $past(gain_q)) |->
            (gain_q == $past(gain_q) + 1'b1 || gain_q == $past(gain_q) - 1'b1));

    assert_gain_after_limit_R7: assert property (@(posedge clk) disable iff (rst)
        (gain_q != $past(gain_q)) |->
            ($past(mode[0]) || $past(sh_q) == SH_TOP || $past(sh_q) <= $past(floor_idx)));
endmodule

// File: rtl/ae_hyst_ctrl.sv
module ae_hyst_ctrl
    import ae_pkg::*;
#(
    parameter int SHUTTER_MAX  = 149,
    parameter int SHUTTER_INIT = 75,
    parameter int LIMIT_STEP   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic [LUMA_W-1:0] luma_in,
    input  logic              backlight_en,
    input  logic [REG_W-1:0]  ref_norm,
    input  logic [REG_W-1:0]  stop_norm,
    input  logic [REG_W-1:0]  restart_norm,
    input  logic [REG_W-1:0]  ref_blc,
    input  logic [REG_W-1:0]  stop_blc,
    input  logic [REG_W-1:0]  restart_blc,
    input  logic [1:0]        exp_mode,
    input  logic [1:0]        step_speed,
    input  logic [1:0]        smooth_sel,
    input  logic [1:0]        limit_sel,
    input  logic [SH_W-1:0]   fixed_shutter,
    input  logic [GAIN_W-1:0] preset_gain,
    output logic [SH_W-1:0]   shutter_idx,
    output logic [GAIN_W-1:0] agc_gain,
    output logic              settled
);
    localparam logic [SH_W-1:0] SH_TOP = SH_W'(SHUTTER_MAX);

    band_t             norm_set, blc_set, active_set;
    logic [LUMA_W-1:0] filt_next;
    logic [SH_W-1:0]   sh_auto;
    logic [GAIN_W-1:0] gain_auto;
    exp_mode_e         mode_e;

    assign norm_set = '{ref_lvl: ref_norm, stop_band: stop_norm, restart_band: restart_norm};
    assign blc_set  = '{ref_lvl: ref_blc,  stop_band: stop_blc,  restart_band: restart_blc};
    assign mode_e   = exp_mode_e'(exp_mode);

    ae_band_sel u_band (
        .use_blc  (backlight_en),
        .norm_set (norm_set),
        .blc_set  (blc_set),
        .active   (active_set)
    );

    ae_luma_filter u_filt (
        .clk       (clk),
        .rst       (rst),
        .stb       (frame_stb),
        .luma      (luma_in),
        .smooth    (smooth_sel),
        .filt_next (filt_next)
    );

    ae_exposure_core #(
        .SHUTTER_MAX  (SHUTTER_MAX),
        .SHUTTER_INIT (SHUTTER_INIT),
        .LIMIT_STEP   (LIMIT_STEP)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .stb       (frame_stb),
        .meas      (filt_next[LUMA_W-1:MEAS_SHIFT]),
        .band      (active_set),
        .mode      (exp_mode),
        .speed     (step_speed),
        .limit_sel (limit_sel),
        .sh_q      (sh_auto),
        .gain_q    (gain_auto),
        .settled_q (settled)
    );

    always_comb begin
        if (mode_e == EXP_FIX_AGC || mode_e == EXP_FIX_NOAGC)
            shutter_idx = (fixed_shutter > SH_TOP) ? SH_TOP : fixed_shutter;
        else
            shutter_idx = sh_auto;
        if (mode_e == EXP_AUTO_NOAGC || mode_e == EXP_FIX_NOAGC)
            agc_gain = preset_gain;
        else
            agc_gain = gain_auto;
    end

    assert_fixed_shutter_legal_R8: assert property (@(posedge clk) disable iff (rst)
        shutter_idx <= SH_TOP);
endmodule

// File: tb/ae_hyst_ctrl_bench.sv
module ae_hyst_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic [11:0] luma_in = '0;
    logic        backlight_en = 1'b0;
    logic [7:0]  ref_norm = 8'h30, stop_norm = 8'h03, restart_norm = 8'h06;
    logic [7:0]  ref_blc = 8'h3A, stop_blc = 8'h04, restart_blc = 8'h08;
    logic [1:0]  exp_mode = 2'b00, step_speed = 2'b10, smooth_sel = 2'b10, limit_sel = 2'b00;
    logic [8:0]  fixed_shutter = 9'd0;
    logic [7:0]  preset_gain = 8'h40;
    logic [8:0]  shutter_idx;
    logic [7:0]  agc_gain;
    logic        settled;

    int errors = 0;
    int checks = 0;
    int m_filt, m_sh, m_gain, m_set;

    always #2.5 clk = ~clk;

    ae_hyst_ctrl u_ae_hyst_ctrl (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .luma_in(luma_in),
        .backlight_en(backlight_en),
        .ref_norm(ref_norm), .stop_norm(stop_norm), .restart_norm(restart_norm),
        .ref_blc(ref_blc), .stop_blc(stop_blc), .restart_blc(restart_blc),
        .exp_mode(exp_mode), .step_speed(step_speed), .smooth_sel(smooth_sel),
        .limit_sel(limit_sel), .fixed_shutter(fixed_shutter), .preset_gain(preset_gain),
        .shutter_idx(shutter_idx), .agc_gain(agc_gain), .settled(settled)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // bench model of one frame, built from the requirements
    function automatic void model_frame(input int l);
        int meas, rf, sb, rb, e, mag, act, step, floor_v;
        if (smooth_sel[1]) m_filt = l;
        else if (smooth_sel[0]) m_filt = (3 * m_filt + l) >> 2;
        else m_filt = (7 * m_filt + l) >> 3;
        meas = m_filt >> 4;
        rf = backlight_en ? ref_blc : ref_norm;
        sb = backlight_en ? stop_blc : stop_norm;
        rb = backlight_en ? restart_blc : restart_norm;
        e = meas - rf;
        mag = (e < 0) ? -e : e;
        act = m_set ? (mag > rb) : (mag > sb);
        if (step_speed[1]) step = 1;
        else if (step_speed[0]) step = 8 + imin(mag / 16, 2);
        else step = 10 + imin(mag / 16, 9);
        floor_v = limit_sel * 16;
        if (act != 0) begin
            if (e < 0) begin
                if (!exp_mode[0] && m_sh < 149) begin
                    m_sh = imin(m_sh + step, 149);
                    if (m_sh < floor_v) m_sh = floor_v;
                end else if (!exp_mode[1] && m_gain < 255) m_gain++;
            end else begin
                if (!exp_mode[0] && m_sh > floor_v)
                    m_sh = (m_sh - floor_v <= step) ? floor_v : m_sh - step;
                else begin
                    if (!exp_mode[0]) m_sh = floor_v;
                    if (!exp_mode[1] && m_gain > 0) m_gain--;
                end
            end
        end
        m_set = (act != 0) ? 0 : 1;
    endfunction

    task automatic check_outputs(input string sh_tag, input string g_tag);
        int exp_sh, exp_g;
        exp_sh = exp_mode[0] ? imin(fixed_shutter, 149) : m_sh;
        exp_g  = exp_mode[1] ? preset_gain : m_gain;
        chk(sh_tag, shutter_idx, exp_sh);
        chk(g_tag, agc_gain, exp_g);
        chk("R4 settled", settled, m_set);
    endtask

    task automatic frame(input int l, input string sh_tag, input string g_tag);
        @(negedge clk);
        luma_in = 12'(l);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        model_frame(l);
        check_outputs(sh_tag, g_tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7741));
        m_filt = 0; m_sh = 75; m_gain = 0; m_set = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset shutter", shutter_idx, 75);
        chk("R1 reset gain", agc_gain, 0);
        chk("R1 reset settled", settled, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset shutter", shutter_idx, 75);

        // R5 single steps, no smoothing, random luminance near the reference
        for (int i = 0; i < 40; i++)
            frame(int'($urandom_range(32'h200, 32'h400)), "R5 shutter fine", "R7 gain");

        // R5 medium and coarse steps with R2 smoothing variants
        step_speed = 2'b01; smooth_sel = 2'b01;
        for (int i = 0; i < 30; i++)
            frame(int'($urandom_range(0, 4095)), "R5 shutter medium", "R2 gain smoothed");
        step_speed = 2'b00; smooth_sel = 2'b00;
        for (int i = 0; i < 30; i++)
            frame(int'($urandom_range(0, 4095)), "R5 shutter coarse", "R2 gain smoothed");

        // R3 backlight set
        backlight_en = 1'b1; smooth_sel = 2'b10; step_speed = 2'b11;
        for (int i = 0; i < 30; i++)
            frame(int'($urandom_range(32'h300, 32'h480)), "R3 shutter blc", "R3 gain blc");
        backlight_en = 1'b0;

        // R6 floor: very bright frames with the highest floor, gain then falls
        limit_sel = 2'b11; step_speed = 2'b00;
        for (int i = 0; i < 12; i++)
            frame(4095, "R6 shutter floor", "R7 gain at floor");
        chk("R6 shutter at floor", shutter_idx, 48);
        // R6 ceiling: black frames
        for (int i = 0; i < 15; i++)
            frame(0, "R6 shutter ceiling", "R7 gain at ceiling");
        chk("R6 shutter at ceiling", shutter_idx, 149);

        // R10 luminance changes without strobe are ignored
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            luma_in = 12'($urandom_range(0, 4095));
        end
        @(negedge clk);
        check_outputs("R10 shutter no strobe", "R10 gain no strobe");

        // R8 fixed shutter above the legal range, R7 gain saturation at 255
        exp_mode = 2'b01; fixed_shutter = 9'd200;
        for (int i = 0; i < 270; i++)
            frame(0, "R8 fixed shutter", "R7 gain saturate");
        chk("R7 gain held at 255", agc_gain, 255);
        fixed_shutter = 9'd37;
        frame(0, "R8 fixed shutter in range", "R7 gain saturate");

        // R9 AGC off uses the preset; internal gain is frozen meanwhile
        exp_mode = 2'b11; preset_gain = 8'h5A;
        for (int i = 0; i < 10; i++)
            frame(4095, "R8 fixed shutter agc off", "R9 preset gain");
        exp_mode = 2'b10;
        for (int i = 0; i < 10; i++)
            frame(int'($urandom_range(0, 4095)), "R6 shutter auto agc off", "R9 preset gain");
        exp_mode = 2'b00; limit_sel = 2'b01;
        frame(4095, "R6 shutter resume", "R9 gain resumes");

        // back to automatic, random mixed traffic
        for (int i = 0; i < 60; i++) begin
            step_speed = 2'($urandom_range(0, 3));
            smooth_sel = 2'($urandom_range(0, 3));
            frame(int'($urandom_range(0, 4095)), "R5 shutter mixed", "R7 gain mixed");
        end

        finish_run();
    end
endmodule